// File: doc/BRIEF.md
# Packet Buffer ID Pool Manager

This block tracks which packet buffers are free and which hold received data. It keeps two small queues of 5-bit buffer IDs, each naming one of 32 buffers of 64 bytes. Software fills a free-list queue with IDs it has released. When the receive engine finishes a packet, it commits the packet. The block then takes the oldest free ID and turns it, together with the packet's length, kind and endpoint, into a completion descriptor. That descriptor goes into a completion queue. Software drains the completion queue by reading a register, and each read removes the entry it returns.

The engine sees the free-list head at all times, so it knows where to write payload before it commits. A refuse flag tells the engine that a commit cannot be accepted, either because no free ID exists or because the completion queue has no room. The engine can then decline the transaction. A refused commit leaves both queues untouched.

Status outputs report both queue depths as 3-bit counts, plus free-list full and completion empty. The interrupt outputs are levels tied to queue state, apart from an overflow event that fires when a write to a full free list is dropped.

Top module: `pkt_buf_id_mgr`

## Requirements
- R1: After reset both depths read 0, `rx_empty_o` is 1, `av_full_o` is 0, `sw_rx_data_o` is 0, `eng_nobuf_o` is 1 and every interrupt output is 0.
- R2: A write on `sw_av_wr_i` while the free list is not full stores `sw_av_id_i` and raises `av_depth_o` by one from the next cycle. `av_full_o` is 1 when the depth equals the free-list capacity (4 by default).
- R3: A write to a full free list is discarded, even if a commit removes an entry in the same cycle. `irq_av_overflow_o` is then high for exactly the following cycle, and the stored IDs are unchanged.
- R4: An accepted commit removes the oldest free ID and appends a descriptor to the completion queue. The 32-bit descriptor word holds the buffer ID in bits 4:0, the byte length in bits 14:8, the kind flag in bit 19 (1 = SETUP, 0 = OUT) and the endpoint in bits 23:20. All other bits are 0.
- R5: `eng_nobuf_o` is 1 whenever the free list is empty or the completion queue is full. A commit made while it is 1 changes neither queue.
- R6: `sw_rx_data_o` shows the oldest completion descriptor while `rx_empty_o` is 0. A read on `sw_rx_rd_i` removes that entry, and entries come out in commit order.
- R7: A read while the completion queue is empty returns 0 and changes no depth and no stored entry.
- R8: `irq_pkt_rcvd_o` is 1 exactly while the completion queue holds at least one entry.
- R9: `irq_av_empty_o` is 1 while the free list is empty, and `irq_rx_full_o` is 1 while the completion queue is full. Both are held at 0 while `enable_i` is 0.
- R10: A write and a commit in the same cycle on a free list that is not full both take effect, leaving its depth unchanged. A read and an accepted commit in the same cycle do the same for the completion queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Interface enabled; gates the status interrupts |
| sw_av_wr_i | input | 1 | Software write strobe for the free list |
| sw_av_id_i | input | 5 | Buffer ID being released |
| sw_rx_rd_i | input | 1 | Software read strobe; removes the completion head |
| sw_rx_data_o | output | 32 | Completion head descriptor, 0 when empty |
| eng_av_id_o | output | 5 | Oldest free buffer ID |
| eng_nobuf_o | output | 1 | Commit would be refused |
| eng_commit_i | input | 1 | Engine packet completion strobe |
| eng_len_i | input | 7 | Received byte count |
| eng_setup_i | input | 1 | 1 for SETUP, 0 for OUT |
| eng_ep_i | input | 4 | Endpoint number |
| av_depth_o | output | 3 | Free-list depth |
| av_full_o | output | 1 | Free list full |
| rx_depth_o | output | 3 | Completion queue depth |
| rx_empty_o | output | 1 | Completion queue empty |
| irq_pkt_rcvd_o | output | 1 | Completion queue not empty |
| irq_av_empty_o | output | 1 | Free list empty while enabled |
| irq_rx_full_o | output | 1 | Completion queue full while enabled |
| irq_av_overflow_o | output | 1 | One-cycle pulse after a dropped write |

## Verification
The assertions assume that every strobe is synchronous to `clk_i` and lasts one cycle per operation. They also assume that software samples `sw_rx_data_o` in the same cycle as the read strobe that removes it. No protocol rule is assumed about when the engine commits, because refused commits are a legal input.

The stimulus changes inputs only on the falling edge and clears every strobe after each rising edge. It deliberately drives writes to a full free list, commits against an empty free list and against a full completion queue, and reads of an empty queue, so the drop and refuse paths are exercised under the same assumptions.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int ID_W      = 5;
  localparam int LEN_W     = 7;
  localparam int EP_W      = 4;
  localparam int WORD_W    = 32;
  localparam int ID_LSB    = 0;
  localparam int LEN_LSB   = 8;
  localparam int SETUP_BIT = 19;
  localparam int EP_LSB    = 20;

  typedef struct packed {
    logic [EP_W-1:0]  ep;
    logic             setup;
    logic [LEN_W-1:0] len;
    logic [ID_W-1:0]  id;
  } rx_desc_t;

  localparam int DESC_W = $bits(rx_desc_t);

  function automatic logic [WORD_W-1:0] desc_to_word(rx_desc_t d);
    logic [WORD_W-1:0] w;
    w                      = '0;
    w[ID_LSB +: ID_W]      = d.id;
    w[LEN_LSB +: LEN_W]    = d.len;
    w[SETUP_BIT]           = d.setup;
    w[EP_LSB +: EP_W]      = d.ep;
    return w;
  endfunction
endpackage

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_comb begin
    wptr_d = push_ok ? ptr_inc(wptr_q) : wptr_q;
    rptr_d = pop_ok ? ptr_inc(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= push_data_i;
  end

  // R2: occupancy never passes capacity
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R3: a push into a full queue with no pop leaves occupancy alone
  a_r3_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
  // R7: a pop from an empty queue with no push leaves occupancy alone
  a_r7_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> $stable(cnt_q) && $stable(rptr_q));
  // R10: a simultaneous legal push and pop keeps occupancy
  a_r10_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o) |=> $stable(cnt_q));
endmodule

// File: rtl/pbuf_irq.sv
module pbuf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic av_empty_i,
  input  logic rx_empty_i,
  input  logic rx_full_i,
  input  logic av_drop_i,
  output logic irq_pkt_rcvd_o,
  output logic irq_av_empty_o,
  output logic irq_rx_full_o,
  output logic irq_av_overflow_o
);
  logic ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= av_drop_i;
  end

  assign irq_pkt_rcvd_o    = !rx_empty_i;
  assign irq_av_empty_o    = enable_i && av_empty_i;
  assign irq_rx_full_o     = enable_i && rx_full_i;
  assign irq_av_overflow_o = ovf_q;

  // R9: status interrupts stay quiet while the interface is disabled
  a_r9_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !irq_av_empty_o && !irq_rx_full_o);
  // R3: overflow is a single-cycle event per dropped write
  a_r3_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_av_overflow_o && !av_drop_i) |=> !irq_av_overflow_o);
endmodule

// File: rtl/pkt_buf_id_mgr.sv
module pkt_buf_id_mgr
  import pbuf_pkg::*;
#(
  parameter int AV_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int STAT_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              sw_av_wr_i,
  input  logic [ID_W-1:0]   sw_av_id_i,
  input  logic              sw_rx_rd_i,
  output logic [WORD_W-1:0] sw_rx_data_o,
  output logic [ID_W-1:0]   eng_av_id_o,
  output logic              eng_nobuf_o,
  input  logic              eng_commit_i,
  input  logic [LEN_W-1:0]  eng_len_i,
  input  logic              eng_setup_i,
  input  logic [EP_W-1:0]   eng_ep_i,
  output logic [STAT_W-1:0] av_depth_o,
  output logic              av_full_o,
  output logic [STAT_W-1:0] rx_depth_o,
  output logic              rx_empty_o,
  output logic              irq_pkt_rcvd_o,
  output logic              irq_av_empty_o,
  output logic              irq_rx_full_o,
  output logic              irq_av_overflow_o
);
  localparam int AV_CNT_W = $clog2(AV_DEPTH + 1);
  localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);

  logic [AV_CNT_W-1:0] av_cnt;
  logic [RX_CNT_W-1:0] rx_cnt;
  logic                av_empty, av_drop, rx_full, rx_drop, commit_ok;
  rx_desc_t            new_desc, rx_head;

  assign eng_nobuf_o = av_empty || rx_full;
  assign commit_ok   = eng_commit_i && !eng_nobuf_o;

  always_comb begin
    new_desc.id    = eng_av_id_o;
    new_desc.len   = eng_len_i;
    new_desc.setup = eng_setup_i;
    new_desc.ep    = eng_ep_i;
  end

  pbuf_fifo #(.WIDTH(ID_W), .DEPTH(AV_DEPTH)) u_av_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (sw_av_wr_i),
    .push_data_i (sw_av_id_i),
    .pop_i       (commit_ok),
    .head_o      (eng_av_id_o),
    .count_o     (av_cnt),
    .full_o      (av_full_o),
    .empty_o     (av_empty),
    .drop_o      (av_drop)
  );

  pbuf_fifo #(.WIDTH(DESC_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (commit_ok),
    .push_data_i (new_desc),
    .pop_i       (sw_rx_rd_i),
    .head_o      (rx_head),
    .count_o     (rx_cnt),
    .full_o      (rx_full),
    .empty_o     (rx_empty_o),
    .drop_o      (rx_drop)
  );

  assign sw_rx_data_o = rx_empty_o ? '0 : desc_to_word(rx_head);
  assign av_depth_o   = STAT_W'(av_cnt);
  assign rx_depth_o   = STAT_W'(rx_cnt);

  pbuf_irq u_irq (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .enable_i          (enable_i),
    .av_empty_i        (av_empty),
    .rx_empty_i        (rx_empty_o),
    .rx_full_i         (rx_full),
    .av_drop_i         (av_drop),
    .irq_pkt_rcvd_o    (irq_pkt_rcvd_o),
    .irq_av_empty_o    (irq_av_empty_o),
    .irq_rx_full_o     (irq_rx_full_o),
    .irq_av_overflow_o (irq_av_overflow_o)
  );

  // R5: refused commits never touch the completion queue
  a_r5_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_commit_i && eng_nobuf_o && !sw_rx_rd_i) |=> $stable(rx_depth_o));
  // R4: accepted commit without a read grows the completion queue by one
  a_r4_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_commit_i && !eng_nobuf_o && !sw_rx_rd_i)
      |=> rx_depth_o == $past(rx_depth_o) + 1'b1);
  // R3: a write seen while full is followed by the overflow event
  a_r3_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_av_wr_i && av_full_o) |=> irq_av_overflow_o);
  // R5: the completion queue never drops, since commits are gated
  a_r5_no_rx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_drop);
  // R7: empty completion queue presents a zero word
  a_r7_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> sw_rx_data_o == '0);
endmodule

// File: tb/pkt_buf_id_mgr_tb_top.sv
module pkt_buf_id_mgr_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 9;

  logic        clk_i = 1'b0;
  logic        rst_ni, enable_i;
  logic        sw_av_wr_i, sw_rx_rd_i, eng_commit_i, eng_setup_i;
  logic [4:0]  sw_av_id_i, eng_av_id_o;
  logic [6:0]  eng_len_i;
  logic [3:0]  eng_ep_i;
  logic [31:0] sw_rx_data_o;
  logic        eng_nobuf_o, av_full_o, rx_empty_o;
  logic [2:0]  av_depth_o, rx_depth_o;
  logic        irq_pkt_rcvd_o, irq_av_empty_o, irq_rx_full_o, irq_av_overflow_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pkt_buf_id_mgr dut_i (
    .clk_i, .rst_ni, .enable_i, .sw_av_wr_i, .sw_av_id_i, .sw_rx_rd_i,
    .sw_rx_data_o, .eng_av_id_o, .eng_nobuf_o, .eng_commit_i, .eng_len_i,
    .eng_setup_i, .eng_ep_i, .av_depth_o, .av_full_o, .rx_depth_o,
    .rx_empty_o, .irq_pkt_rcvd_o, .irq_av_empty_o, .irq_rx_full_o,
    .irq_av_overflow_o
  );

  // vector: op[39:38] (1 write, 2 commit, 3 read), arg[37:6], exp av[5:3], exp rx[2:0]
  // commit arg: len [6:0], setup [7], ep [11:8]; read arg: expected word
  localparam logic [39:0] VEC [NV] = '{
    {2'd1, 32'd3,          3'd1, 3'd0},
    {2'd1, 32'd7,          3'd2, 3'd0},
    {2'd1, 32'd12,         3'd3, 3'd0},
    {2'd1, 32'd31,         3'd4, 3'd0},
    {2'd2, 32'h000000C0,   3'd3, 3'd1},
    {2'd2, 32'h00000508,   3'd2, 3'd2},
    {2'd3, 32'h00084003,   3'd2, 3'd1},
    {2'd3, 32'h00500807,   3'd2, 3'd0},
    {2'd1, 32'd1,          3'd3, 3'd0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sw_av_wr_i = 0; sw_av_id_i = 0; sw_rx_rd_i = 0;
    eng_commit_i = 0; eng_len_i = 0; eng_setup_i = 0; eng_ep_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    idle_inputs();
    #1;
  endtask

  task automatic set_commit(input logic [6:0] len, input logic setup, input logic [3:0] ep);
    eng_commit_i = 1; eng_len_i = len; eng_setup_i = setup; eng_ep_i = ep;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    enable_i = 0;
    rst_ni   = 0;
    #(CLK_P * 3);
    @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk(av_depth_o, 0, "R1 av_depth");
    chk(rx_depth_o, 0, "R1 rx_depth");
    chk(rx_empty_o, 1, "R1 rx_empty");
    chk(av_full_o, 0, "R1 av_full");
    chk(sw_rx_data_o, 0, "R1 rx_data");
    chk(eng_nobuf_o, 1, "R1 nobuf");
    chk({irq_pkt_rcvd_o, irq_av_empty_o, irq_rx_full_o, irq_av_overflow_o}, 0, "R1 irqs");
    // R9 gating: empty free list but disabled
    chk(irq_av_empty_o, 0, "R9 disabled gate");
    enable_i = 1; #1;
    chk(irq_av_empty_o, 1, "R9 av empty enabled");
    // R7 read of empty queue
    sw_rx_rd_i = 1; #1;
    chk(sw_rx_data_o, 0, "R7 empty read word");
    tick();
    chk(rx_depth_o, 0, "R7 rx depth");
    chk(av_depth_o, 0, "R7 av depth");

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      case (v[39:38])
        2'd1: begin sw_av_wr_i = 1; sw_av_id_i = v[10:6]; end
        2'd2: set_commit(v[12:6], v[13], v[17:14]);
        2'd3: begin
          sw_rx_rd_i = 1; #1;
          chk(sw_rx_data_o, v[37:6], "R4 R6 descriptor word");
        end
        default: ;
      endcase
      tick();
      chk(av_depth_o, v[5:3], "R2 av depth");
      chk(rx_depth_o, v[2:0], "R6 rx depth");
      if (i == 3) chk(av_full_o, 1, "R2 av full");
      if (i == 4) chk(irq_pkt_rcvd_o, 1, "R8 irq with entry");
    end
    chk(irq_pkt_rcvd_o, 0, "R8 irq cleared");
    chk(irq_av_empty_o, 0, "R9 av not empty");

    // free list holds 12,31,1; fill then overflow
    sw_av_wr_i = 1; sw_av_id_i = 5'd9; tick();
    chk(av_full_o, 1, "R2 full again");
    sw_av_wr_i = 1; sw_av_id_i = 5'd20; tick();
    chk(av_depth_o, 4, "R3 dropped write depth");
    chk(irq_av_overflow_o, 1, "R3 overflow pulse");
    tick();
    chk(irq_av_overflow_o, 0, "R3 overflow ends");

    for (int k = 1; k <= 4; k++) begin
      set_commit(7'(k), 1'b0, 4'(k));
      tick();
    end
    chk(av_depth_o, 0, "R4 av drained");
    chk(rx_depth_o, 4, "R4 rx filled");
    chk(irq_rx_full_o, 1, "R9 rx full irq");
    chk(irq_av_empty_o, 1, "R9 av empty irq");
    chk(eng_nobuf_o, 1, "R5 nobuf both");
    set_commit(7'd9, 1'b0, 4'd9); tick();
    chk(rx_depth_o, 4, "R5 refused rx");
    sw_av_wr_i = 1; sw_av_id_i = 5'd2; tick();
    chk(eng_nobuf_o, 1, "R5 nobuf rx full");
    set_commit(7'd9, 1'b0, 4'd9); tick();
    chk(av_depth_o, 1, "R5 refused av kept");
    chk(rx_depth_o, 4, "R5 refused rx kept");
    enable_i = 0; #1;
    chk(irq_rx_full_o, 0, "R9 rx full gated");
    enable_i = 1;

    sw_rx_rd_i = 1; #1;
    chk(sw_rx_data_o, 32'h0010010C, "R6 head id12");
    tick();
    chk(rx_depth_o, 3, "R6 rx after read");
    sw_rx_rd_i = 1; set_commit(7'd5, 1'b0, 4'd5); #1;
    chk(sw_rx_data_o, 32'h0020021F, "R6 head id31");
    tick();
    chk(rx_depth_o, 3, "R10 rx read+commit");
    chk(av_depth_o, 0, "R10 av popped");
    sw_av_wr_i = 1; sw_av_id_i = 5'd6; tick();
    sw_av_wr_i = 1; sw_av_id_i = 5'd8; set_commit(7'd6, 1'b1, 4'd6); tick();
    chk(av_depth_o, 1, "R10 av write+commit");
    chk(rx_depth_o, 4, "R10 rx grew");

    begin
      logic [31:0] exp_w [4] = '{32'h00300301, 32'h00400409, 32'h00500502, 32'h00680606};
      for (int j = 0; j < 4; j++) begin
        sw_rx_rd_i = 1; #1;
        chk(sw_rx_data_o, exp_w[j], "R6 drain order");
        tick();
      end
    end
    chk(rx_empty_o, 1, "R6 drained empty");
    chk(eng_av_id_o, 5'd8, "R4 free head");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule